// File: doc/BRIEF.md
# Charge Pump Current-Mode Controller

This block is the digital control for a tristate phase-frequency detector and the charge pump it drives in a frequency synthesizer. It receives single-cycle event pulses from the reference divider and from the feedback (VCO) divider. It produces the UP and DOWN pump pulses, and it measures how many clock cycles each phase error lasts. Each completed error is compared against a programmable lock window. A chain of consecutive in-window errors declares lock.

The pump is driven with one of two current settings, each supplied as a separate code. Large phase errors and divider reprogramming put the pump into the high setting. Once lock is declared, the pump can fall back to the low setting in one of two ways. It either drops automatically, or, with the automatic path disabled, it waits for a software command. The selected current code goes out to the analog pump every cycle.

Top module: `cpc_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pump_up` and `pump_dn` are 0, `hi_sel` is 1, `locked` is 0 and `cur_code` equals `hi_code`.
- R2: A `ref_evt` sampled at a clock edge makes `pump_up` 1 after that edge, and an `fb_evt` does the same for `pump_dn`. When both are 1, both return to 0 at the next edge, so they are never 1 together for more than one cycle.
- R3: An error's width is the number of cycles between the reference event and the feedback event, in either order; simultaneous events give width 0. The width counts as in-window when it is at most `win_code`+1 cycles, so codes 0, 1, 2 and 3 give windows of 1, 2, 3 and 4 cycles.
- R4: The in-window count starts from the last clear. `locked` becomes 1 at the comparison that brings this count to 2^(`cnt_code`+1), so codes 0 to 3 need 2, 4, 8 or 16 comparisons. `locked` then stays 1 while further comparisons remain in-window.
- R5: A single out-of-window comparison clears the consecutive count, clears `locked` and sets `hi_sel` to 1 at the same edge.
- R6: With `auto_en`=1, `hi_sel` falls to 0 one cycle after `locked` becomes 1.
- R7: With `auto_en`=0, lock leaves `hi_sel` unchanged, and an `sw_low` pulse sets `hi_sel` to 0 at the next edge. With `auto_en`=1, `sw_low` has no effect.
- R8: A `div_load` pulse sets `hi_sel` to 1, clears `locked` and clears the consecutive count at the next edge. It takes priority over every other cause.
- R9: `cur_code` equals `hi_code` while `hi_sel` is 1 and `lo_code` while it is 0, in the same cycle.
- R10: The width meter saturates at its maximum value instead of wrapping, so a very long error (for example 257 cycles) is never judged in-window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_evt | input | 1 | One-cycle pulse from the reference divider |
| fb_evt | input | 1 | One-cycle pulse from the feedback divider |
| div_load | input | 1 | Pulse when the divider is reprogrammed |
| auto_en | input | 1 | 1: drop to low current on lock; 0: wait for software |
| sw_low | input | 1 | Software command to select low current |
| win_code | input | 2 | Lock window, code+1 cycles |
| cnt_code | input | 2 | Lock count, 2^(code+1) comparisons |
| hi_code | input | CUR_W | High-current magnitude |
| lo_code | input | CUR_W | Low-current magnitude |
| pump_up | output | 1 | Pump UP pulse |
| pump_dn | output | 1 | Pump DOWN pulse |
| hi_sel | output | 1 | 1 when the high-current setting is selected |
| cur_code | output | CUR_W | Selected current magnitude |
| locked | output | 1 | Lock declared |

## Verification
The hardest state to reach is the window boundary combined with a full lock chain. An error exactly one cycle wider than the window must break lock, while one exactly at the window must extend it. Lock appears only after up to 16 consecutive comparisons. The stimulus places event pairs at exact cycle skews from 0 to 5, in both orders, for every window code, and runs complete chains for every count code before breaking them with one wide error. A 257-cycle skew reaches meter saturation, which a wrapping counter would misread as a 1-cycle error.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic {
        CUR_LOW  = 1'b0,
        CUR_HIGH = 1'b1
    } cur_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_t;

    typedef struct packed {
        logic valid;
        logic in_win;
    } cmp_t;

    localparam int unsigned LOCK_MAX = 16;

    function automatic int unsigned win_cycles(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

    function automatic int unsigned lock_target(input logic [1:0] code);
        return 2 << code;
    endfunction

endpackage

// File: rtl/cpc_pfd.sv
module cpc_pfd
    import cpc_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_evt,
    input  logic               fb_evt,
    output pfd_t               pfd,
    output logic               done,
    output logic [WIDTH_W-1:0] width
);
    localparam logic [WIDTH_W-1:0] METER_MAX = {WIDTH_W{1'b1}};

    pfd_t               st;
    logic [WIDTH_W-1:0] meter;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            meter <= '0;
        end else if (st.up && st.dn) begin
            st    <= '0;
            meter <= '0;
        end else begin
            st.up <= st.up | ref_evt;
            st.dn <= st.dn | fb_evt;
            if ((st.up ^ st.dn) && (meter != METER_MAX))
                meter <= meter + WIDTH_W'(1);
        end
    end

    assign pfd   = st;
    assign done  = st.up && st.dn;
    assign width = meter;
endmodule

// File: rtl/cpc_lock.sv
module cpc_lock
    import cpc_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               done,
    input  logic [WIDTH_W-1:0] width,
    input  logic [1:0]         win_code,
    input  logic [1:0]         cnt_code,
    output cmp_t               cmp,
    output logic               locked
);
    localparam int LCNT_W = $clog2(LOCK_MAX + 1);

    logic [LCNT_W-1:0]  cnt, cnt_n, target;
    logic [WIDTH_W-1:0] limit;

    always_comb begin
        limit      = WIDTH_W'(win_cycles(win_code));
        target     = LCNT_W'(lock_target(cnt_code));
        cmp.valid  = done;
        cmp.in_win = (width <= limit);
        cnt_n      = (cnt >= target) ? target : cnt + LCNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (cmp.valid) begin
            if (cmp.in_win) begin
                cnt    <= cnt_n;
                locked <= (cnt_n >= target);
            end else begin
                cnt    <= '0;
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cpc_mode.sv
module cpc_mode
    import cpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      div_load,
    input  cmp_t      cmp,
    input  logic      auto_en,
    input  logic      locked,
    input  logic      sw_low,
    output cur_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)
            mode <= CUR_HIGH;
        else if (div_load)
            mode <= CUR_HIGH;
        else if (cmp.valid && !cmp.in_win)
            mode <= CUR_HIGH;
        else if (auto_en && locked)
            mode <= CUR_LOW;
        else if (!auto_en && sw_low)
            mode <= CUR_LOW;
    end
endmodule

// File: rtl/cpc_ctrl.sv
module cpc_ctrl
    import cpc_pkg::*;
#(
    parameter int CUR_W   = 6,
    parameter int WIDTH_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_evt,
    input  logic             fb_evt,
    input  logic             div_load,
    input  logic             auto_en,
    input  logic             sw_low,
    input  logic [1:0]       win_code,
    input  logic [1:0]       cnt_code,
    input  logic [CUR_W-1:0] hi_code,
    input  logic [CUR_W-1:0] lo_code,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             hi_sel,
    output logic [CUR_W-1:0] cur_code,
    output logic             locked
);
    pfd_t               pfd;
    logic               done;
    logic [WIDTH_W-1:0] width;
    cmp_t               cmp;
    cur_mode_e          mode;

    cpc_pfd #(.WIDTH_W(WIDTH_W)) u_pfd (
        .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt),
        .pfd(pfd), .done(done), .width(width)
    );

    cpc_lock #(.WIDTH_W(WIDTH_W)) u_lock (
        .clk(clk), .rst(rst), .clr(div_load), .done(done), .width(width),
        .win_code(win_code), .cnt_code(cnt_code), .cmp(cmp), .locked(locked)
    );

    cpc_mode u_mode (
        .clk(clk), .rst(rst), .div_load(div_load), .cmp(cmp),
        .auto_en(auto_en), .locked(locked), .sw_low(sw_low), .mode(mode)
    );

    assign pump_up  = pfd.up;
    assign pump_dn  = pfd.dn;
    assign hi_sel   = (mode == CUR_HIGH);
    assign cur_code = hi_sel ? hi_code : lo_code;
endmodule

// File: rtl/cpc_ctrl_chk.sv
module cpc_ctrl_chk #(
    parameter int CUR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             div_load,
    input logic             auto_en,
    input logic             sw_low,
    input logic             pump_up,
    input logic             pump_dn,
    input logic             hi_sel,
    input logic             locked
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (hi_sel && !locked && !pump_up && !pump_dn));

    p_overlap_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (pump_up && pump_dn) |=> (!pump_up && !pump_dn));

    p_lock_on_compare_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(pump_up && pump_dn));

    p_auto_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_en && locked && !div_load && !(pump_up && pump_dn)) |=> !hi_sel);

    p_manual_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !sw_low && !div_load && !(pump_up && pump_dn)) |=> $stable(hi_sel));

    p_sw_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !locked && hi_sel) |=> hi_sel);

    p_div_load_r8: assert property (@(posedge clk) disable iff (rst)
        div_load |=> (hi_sel && !locked));
endmodule

bind cpc_ctrl cpc_ctrl_chk #(.CUR_W(CUR_W)) u_chk (
    .clk(clk), .rst(rst), .div_load(div_load), .auto_en(auto_en),
    .sw_low(sw_low), .pump_up(pump_up), .pump_dn(pump_dn),
    .hi_sel(hi_sel), .locked(locked)
);

// File: tb/cpc_ctrl_test.sv
module cpc_ctrl_test;
    localparam int CUR_W = 6;
    localparam logic [CUR_W-1:0] HI = 6'h2A;
    localparam logic [CUR_W-1:0] LO = 6'h05;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_evt = 1'b0, fb_evt = 1'b0, div_load = 1'b0;
    logic auto_en = 1'b1, sw_low = 1'b0;
    logic [1:0] win_code = 2'd0, cnt_code = 2'd0;
    logic pump_up, pump_dn, hi_sel, locked;
    logic [CUR_W-1:0] cur_code;

    int checks = 0, fails = 0;
    int m_cnt = 0;
    bit m_locked = 1'b0, m_hi = 1'b1;

    always #4 clk = ~clk;

    cpc_ctrl #(.CUR_W(CUR_W)) uut (
        .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt),
        .div_load(div_load), .auto_en(auto_en), .sw_low(sw_low),
        .win_code(win_code), .cnt_code(cnt_code), .hi_code(HI), .lo_code(LO),
        .pump_up(pump_up), .pump_dn(pump_dn), .hi_sel(hi_sel),
        .cur_code(cur_code), .locked(locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " locked"}, int'(locked), int'(m_locked));
        chk({req, " hi_sel"}, int'(hi_sel), int'(m_hi));
        chk("R9 cur_code", int'(cur_code), int'(m_hi ? HI : LO));
    endtask

    task automatic do_load();
        @(negedge clk) div_load = 1'b1;
        @(negedge clk) div_load = 1'b0;
        m_cnt = 0; m_locked = 1'b0; m_hi = 1'b1;
        chk_state("R8");
    endtask

    task automatic do_sw_low();
        @(negedge clk) sw_low = 1'b1;
        @(negedge clk) sw_low = 1'b0;
        if (!auto_en) m_hi = 1'b0;
        chk_state("R7");
    endtask

    // skew k cycles between the two divider events
    task automatic phase_event(input int k, input bit fb_first);
        int target;
        bit inwin;
        @(negedge clk);
        if (k == 0) begin ref_evt = 1'b1; fb_evt = 1'b1; end
        else if (fb_first) fb_evt = 1'b1;
        else ref_evt = 1'b1;
        @(negedge clk);
        ref_evt = 1'b0; fb_evt = 1'b0;
        if (k != 0) begin
            chk("R2 leading flag", int'(fb_first ? pump_dn : pump_up), 1);
            chk("R2 trailing flag", int'(fb_first ? pump_up : pump_dn), 0);
            repeat (k - 1) @(negedge clk);
            if (fb_first) ref_evt = 1'b1; else fb_evt = 1'b1;
            @(negedge clk);
            ref_evt = 1'b0; fb_evt = 1'b0;
        end
        chk("R2 overlap", int'(pump_up && pump_dn), 1);
        @(negedge clk);
        chk("R2 clear", int'(pump_up || pump_dn), 0);
        target = 2 << cnt_code;
        inwin  = (k <= int'(win_code) + 1);
        if (inwin) begin
            m_cnt    = (m_cnt >= target) ? target : m_cnt + 1;
            m_locked = (m_cnt >= target);
        end else begin
            m_cnt = 0; m_locked = 1'b0; m_hi = 1'b1;
        end
        @(negedge clk);
        if (auto_en && m_locked) m_hi = 1'b0;
        chk_state(inwin ? "R3/R4/R6" : "R3/R5");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R1 up", int'(pump_up), 0);
        chk("R1 dn", int'(pump_dn), 0);
        chk_state("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1");

        // R3: window boundary sweep, both event orders
        auto_en = 1'b1; cnt_code = 2'd0;
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 6; k++) begin
                win_code = 2'(w);
                do_load();
                phase_event(k, k[0]);
                phase_event(k, ~k[0]);
            end
        end

        // R4/R5: full chains for each count code, then one wide error
        win_code = 2'd1;
        for (int c = 0; c < 4; c++) begin
            cnt_code = 2'(c);
            do_load();
            for (int n = 0; n < (2 << c); n++) phase_event(n % 3, n[0]);
            phase_event(1, 1'b0);
            phase_event(5, 1'b1);
        end

        // R10: saturation of the width meter
        win_code = 2'd3; cnt_code = 2'd0;
        do_load();
        phase_event(257, 1'b0);
        phase_event(257, 1'b1);

        // R7: manual mode
        auto_en = 1'b0;
        do_load();
        phase_event(0, 1'b0);
        phase_event(1, 1'b0);
        do_sw_low();
        // R8: reprogramming from low current while locked
        do_load();

        // R7: command ignored in automatic mode before lock
        auto_en = 1'b1;
        do_load();
        do_sw_low();
        // R6 then R8
        phase_event(2, 1'b0);
        phase_event(2, 1'b1);
        do_load();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule